// File: doc/BRIEF.md
# Address Translation and Protection Unit

This block turns a 52-bit effective address into a 32-bit physical address using a small set of translation entries that software loads through a write port. There are two banks of entries. Block entries cover a large, power-of-two region: a per-entry mask selects which low page-number bits are ignored in the compare and copied straight into the physical address. Page entries each map one 4 KB page by an exact page-number compare. When both banks match, a block entry takes precedence over a page entry.

Every request also carries a privilege level (supervisor or user) and an access kind (load, store or instruction fetch). The access is checked against the permission bits of the matching entry. A per-entry key bit reports a user-mode violation before any further checking is done. For page entries the unit keeps a referenced bit and a changed bit, which it sets itself on permitted accesses. A request that matches no entry reports a miss for software to service. The result is registered and appears one cycle after the request.

Top module: `xlat_unit`

## Requirements
- R1: `res_vld` is high exactly in the cycle after a cycle with `req_vld` high. After reset, `res_vld` and `res_hit` are 0.
- R2: A valid page entry matches only when its 40-bit page number equals `req_va[51:12]` exactly. The result is then `res_pa = {ppn, req_va[11:0]}`, and `res_attr` returns the entry's 3-bit attribute field {write-through, cache-inhibit, coherent}.
- R3: A valid block entry ignores the page-number bits whose `wr_mask` bit is 1 (mask bit k applies to page-number bit k) and compares all other page-number bits. In the resulting page frame, masked bits come from the request's page number and unmasked bits come from the entry.
- R4: A block match takes precedence over any page match. Within one bank, the matching entry with the lowest index is used.
- R5: If nothing matches, `res_cause` is 1 (miss), `res_hit` is 0, and `res_pa`, `res_attr`, `res_ref` and `res_chg` are all 0.
- R6: Permission field `wr_perm` = {exec, sup_write, user_write, user_read}. The rules are:
  - a supervisor may always load;
  - a user load needs user_read;
  - a store needs sup_write (supervisor) or user_write (user);
  - a fetch needs exec, and for a user it also needs user_read.
  A denied access gives `res_cause` 2 with `res_pa` and `res_attr` both 0.
- R7: A user access that hits an entry whose key bit is set gives `res_cause` 3, whatever its permission bits. Supervisor accesses ignore the key bit.
- R8: A permitted access through a page entry sets that entry's referenced bit, and a permitted store also sets its changed bit. `res_ref`/`res_chg` show the entry's bits including this access. A denied access shows the bits unchanged and leaves them unchanged. A block hit shows 0 for both. Success is `res_cause` 0 with `res_hit` 1.
- R9: A write (`wr_page` 1 = page bank, 0 = block bank) loads the entry selected by `wr_idx` and clears its referenced and changed bits; `wr_vld` 0 invalidates the entry. A lookup in the same cycle as a write uses the old contents. If a write and a status update hit the same page entry in the same cycle, the write wins.
- R10: `req_kind` is encoded as 0 = load, 1 = store, 2 = fetch, and the value 3 is handled as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request valid |
| req_va | input | 52 | Effective address |
| req_priv | input | 1 | 1 = supervisor, 0 = user |
| req_kind | input | 2 | Access kind (R10) |
| wr_en | input | 1 | Entry write strobe |
| wr_page | input | 1 | 1 = page bank, 0 = block bank |
| wr_idx | input | 3 | Entry index |
| wr_vld | input | 1 | Valid bit to store |
| wr_vpn | input | 40 | Page number tag |
| wr_mask | input | 20 | Block size mask (block bank only) |
| wr_ppn | input | 20 | Physical page frame |
| wr_perm | input | 4 | {exec, sup_write, user_write, user_read} |
| wr_attr | input | 3 | {write-through, cache-inhibit, coherent} |
| wr_key | input | 1 | Key bit |
| res_vld | output | 1 | Result valid |
| res_pa | output | 32 | Physical address |
| res_attr | output | 3 | Attribute bits |
| res_hit | output | 1 | Translation succeeded |
| res_cause | output | 2 | 0 ok, 1 miss, 2 permission, 3 key |
| res_ref | output | 1 | Page referenced bit |
| res_chg | output | 1 | Page changed bit |

## Verification
The risky overlap is an entry write and a permitted access landing on the same page entry in one cycle. In that cycle the lookup must still use the old mapping, while its status update is overridden by the write's clearing of referenced and changed. The bench issues a store and a rewrite of the same page entry in a single cycle. It then checks that the store's result carries the old frame with both status bits set, and that the load that follows sees the new frame with only the referenced bit set. A behavioural model of the entry banks predicts every result, including this ordering.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int ATTR_W = 3;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MISS = 2'd1,
    CAUSE_PERM = 2'd2,
    CAUSE_KEY  = 2'd3
  } cause_e;

  typedef struct packed {
    logic exec;
    logic sup_wr;
    logic usr_wr;
    logic usr_rd;
  } perm_t;
endpackage

// File: rtl/xlat_blk_array.sv
module xlat_blk_array
  import xlat_pkg::*;
#(
  parameter int VPN_W = 40,
  parameter int PPN_W = 20,
  parameter int N     = 4,
  parameter int IW    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic               wr_vld,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_mask,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  perm_t              wr_perm,
  input  logic [ATTR_W-1:0]  wr_attr,
  input  logic               wr_key,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit,
  output logic [PPN_W-1:0]   hit_ppn,
  output perm_t              hit_perm,
  output logic [ATTR_W-1:0]  hit_attr,
  output logic               hit_key
);
  logic [N-1:0]        vld_q, vld_d;
  logic [VPN_W-1:0]    vpn_q  [N];
  logic [VPN_W-1:0]    vpn_d  [N];
  logic [PPN_W-1:0]    mask_q [N];
  logic [PPN_W-1:0]    mask_d [N];
  logic [PPN_W-1:0]    ppn_q  [N];
  logic [PPN_W-1:0]    ppn_d  [N];
  perm_t               perm_q [N];
  perm_t               perm_d [N];
  logic [ATTR_W-1:0]   attr_q [N];
  logic [ATTR_W-1:0]   attr_d [N];
  logic [N-1:0]        key_q, key_d;

  // next state
  always_comb begin
    vld_d  = vld_q;
    vpn_d  = vpn_q;
    mask_d = mask_q;
    ppn_d  = ppn_q;
    perm_d = perm_q;
    attr_d = attr_q;
    key_d  = key_q;
    if (wr_en) begin
      vld_d[wr_idx]  = wr_vld;
      vpn_d[wr_idx]  = wr_vpn;
      mask_d[wr_idx] = wr_mask;
      ppn_d[wr_idx]  = wr_ppn;
      perm_d[wr_idx] = wr_perm;
      attr_d[wr_idx] = wr_attr;
      key_d[wr_idx]  = wr_key;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      key_q <= '0;
      for (int i = 0; i < N; i++) begin
        vpn_q[i]  <= '0;
        mask_q[i] <= '0;
        ppn_q[i]  <= '0;
        perm_q[i] <= '0;
        attr_q[i] <= '0;
      end
    end else if (wr_en) begin
      vld_q  <= vld_d;
      key_q  <= key_d;
      vpn_q  <= vpn_d;
      mask_q <= mask_d;
      ppn_q  <= ppn_d;
      perm_q <= perm_d;
      attr_q <= attr_d;
    end
  end

  // per-entry masked compare
  logic [N-1:0] match;
  for (genvar g = 0; g < N; g++) begin : g_match
    logic [VPN_W-1:0] care;
    assign care     = ~{{(VPN_W-PPN_W){1'b0}}, mask_q[g]};
    assign match[g] = vld_q[g] && (((lk_vpn ^ vpn_q[g]) & care) == '0);
  end

  // lowest index wins
  logic [IW-1:0] sel;
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IW'(i);
      end
    end
  end

  assign hit_ppn  = (ppn_q[sel] & ~mask_q[sel]) | (lk_vpn[PPN_W-1:0] & mask_q[sel]);
  assign hit_perm = perm_q[sel];
  assign hit_attr = attr_q[sel];
  assign hit_key  = key_q[sel];
endmodule

// File: rtl/xlat_pg_array.sv
module xlat_pg_array
  import xlat_pkg::*;
#(
  parameter int VPN_W = 40,
  parameter int PPN_W = 20,
  parameter int N     = 8,
  parameter int IW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic               wr_vld,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  perm_t              wr_perm,
  input  logic [ATTR_W-1:0]  wr_attr,
  input  logic               wr_key,
  input  logic               upd_en,
  input  logic [IW-1:0]      upd_idx,
  input  logic               upd_store,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit,
  output logic [IW-1:0]      hit_idx,
  output logic [PPN_W-1:0]   hit_ppn,
  output perm_t              hit_perm,
  output logic [ATTR_W-1:0]  hit_attr,
  output logic               hit_key,
  output logic               hit_ref,
  output logic               hit_chg
);
  logic [N-1:0]        vld_q, vld_d;
  logic [N-1:0]        ref_q, ref_d;
  logic [N-1:0]        chg_q, chg_d;
  logic [N-1:0]        key_q, key_d;
  logic [VPN_W-1:0]    vpn_q  [N];
  logic [VPN_W-1:0]    vpn_d  [N];
  logic [PPN_W-1:0]    ppn_q  [N];
  logic [PPN_W-1:0]    ppn_d  [N];
  perm_t               perm_q [N];
  perm_t               perm_d [N];
  logic [ATTR_W-1:0]   attr_q [N];
  logic [ATTR_W-1:0]   attr_d [N];

  // next state: status update first, a write to the same entry overrides it
  always_comb begin
    vld_d  = vld_q;
    ref_d  = ref_q;
    chg_d  = chg_q;
    key_d  = key_q;
    vpn_d  = vpn_q;
    ppn_d  = ppn_q;
    perm_d = perm_q;
    attr_d = attr_q;
    if (upd_en) begin
      ref_d[upd_idx] = 1'b1;
      if (upd_store) chg_d[upd_idx] = 1'b1;
    end
    if (wr_en) begin
      vld_d[wr_idx]  = wr_vld;
      ref_d[wr_idx]  = 1'b0;
      chg_d[wr_idx]  = 1'b0;
      key_d[wr_idx]  = wr_key;
      vpn_d[wr_idx]  = wr_vpn;
      ppn_d[wr_idx]  = wr_ppn;
      perm_d[wr_idx] = wr_perm;
      attr_d[wr_idx] = wr_attr;
    end
  end

  // status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ref_q <= '0;
      chg_q <= '0;
    end else if (wr_en || upd_en) begin
      vld_q <= vld_d;
      ref_q <= ref_d;
      chg_q <= chg_d;
    end
  end

  // entry data registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      for (int i = 0; i < N; i++) begin
        vpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        perm_q[i] <= '0;
        attr_q[i] <= '0;
      end
    end else if (wr_en) begin
      key_q  <= key_d;
      vpn_q  <= vpn_d;
      ppn_q  <= ppn_d;
      perm_q <= perm_d;
      attr_q <= attr_d;
    end
  end

  logic [N-1:0] match;
  for (genvar g = 0; g < N; g++) begin : g_match
    assign match[g] = vld_q[g] && (lk_vpn == vpn_q[g]);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign hit_ppn  = ppn_q[hit_idx];
  assign hit_perm = perm_q[hit_idx];
  assign hit_attr = attr_q[hit_idx];
  assign hit_key  = key_q[hit_idx];
  assign hit_ref  = ref_q[hit_idx];
  assign hit_chg  = chg_q[hit_idx];
endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_pkg::*;
(
  input  logic   priv,
  input  kind_e  kind,
  input  perm_t  perm,
  input  logic   key,
  output cause_e cause
);
  logic allowed;

  always_comb begin
    unique case (kind)
      KIND_STORE: allowed = priv ? perm.sup_wr : perm.usr_wr;
      KIND_FETCH: allowed = perm.exec && (priv || perm.usr_rd);
      default:    allowed = priv || perm.usr_rd;
    endcase
  end

  always_comb begin
    if (key && !priv)  cause = CAUSE_KEY;
    else if (!allowed) cause = CAUSE_PERM;
    else               cause = CAUSE_NONE;
  end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter  int VA_W  = 52,
  parameter  int PA_W  = 32,
  parameter  int OFS_W = 12,
  parameter  int NBLK  = 4,
  parameter  int NPG   = 8,
  localparam int VPN_W = VA_W - OFS_W,
  localparam int PPN_W = PA_W - OFS_W,
  localparam int BIW   = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int PIW   = (NPG  > 1) ? $clog2(NPG)  : 1,
  localparam int IW    = (BIW > PIW) ? BIW : PIW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_priv,
  input  logic [1:0]        req_kind,
  input  logic              wr_en,
  input  logic              wr_page,
  input  logic [IW-1:0]     wr_idx,
  input  logic              wr_vld,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_mask,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [3:0]        wr_perm,
  input  logic [2:0]        wr_attr,
  input  logic              wr_key,
  output logic              res_vld,
  output logic [PA_W-1:0]   res_pa,
  output logic [2:0]        res_attr,
  output logic              res_hit,
  output logic [1:0]        res_cause,
  output logic              res_ref,
  output logic              res_chg
);
  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  logic [VPN_W-1:0] lk_vpn;
  logic [OFS_W-1:0] lk_ofs;
  kind_e            kind;
  assign lk_vpn = req_va[VA_W-1:OFS_W];
  assign lk_ofs = req_va[OFS_W-1:0];
  assign kind   = kind_e'(req_kind);

  logic blk_wr, pg_wr;
  assign blk_wr = wr_en && !wr_page && (int'(wr_idx) < NBLK);
  assign pg_wr  = wr_en &&  wr_page && (int'(wr_idx) < NPG);

  logic              b_hit, b_key;
  logic [PPN_W-1:0]  b_ppn;
  perm_t             b_perm;
  logic [2:0]        b_attr;

  xlat_blk_array #(.VPN_W(VPN_W), .PPN_W(PPN_W), .N(NBLK), .IW(BIW)) u_blk (
    .clk(clk), .rst_n(rst_s),
    .wr_en(blk_wr), .wr_idx(wr_idx[BIW-1:0]), .wr_vld(wr_vld), .wr_vpn(wr_vpn),
    .wr_mask(wr_mask), .wr_ppn(wr_ppn), .wr_perm(perm_t'(wr_perm)),
    .wr_attr(wr_attr), .wr_key(wr_key),
    .lk_vpn(lk_vpn),
    .hit(b_hit), .hit_ppn(b_ppn), .hit_perm(b_perm), .hit_attr(b_attr), .hit_key(b_key)
  );

  logic              p_hit, p_key, p_ref, p_chg;
  logic [PIW-1:0]    p_idx;
  logic [PPN_W-1:0]  p_ppn;
  perm_t             p_perm;
  logic [2:0]        p_attr;
  logic              upd_en, upd_store;

  xlat_pg_array #(.VPN_W(VPN_W), .PPN_W(PPN_W), .N(NPG), .IW(PIW)) u_pg (
    .clk(clk), .rst_n(rst_s),
    .wr_en(pg_wr), .wr_idx(wr_idx[PIW-1:0]), .wr_vld(wr_vld), .wr_vpn(wr_vpn),
    .wr_ppn(wr_ppn), .wr_perm(perm_t'(wr_perm)), .wr_attr(wr_attr), .wr_key(wr_key),
    .upd_en(upd_en), .upd_idx(p_idx), .upd_store(upd_store),
    .lk_vpn(lk_vpn),
    .hit(p_hit), .hit_idx(p_idx), .hit_ppn(p_ppn), .hit_perm(p_perm),
    .hit_attr(p_attr), .hit_key(p_key), .hit_ref(p_ref), .hit_chg(p_chg)
  );

  // block bank has priority
  logic              pg_sel;
  logic [PPN_W-1:0]  sel_ppn;
  perm_t             sel_perm;
  logic [2:0]        sel_attr;
  logic              sel_key;
  always_comb begin
    pg_sel = !b_hit && p_hit;
    if (b_hit) begin
      sel_ppn  = b_ppn;
      sel_perm = b_perm;
      sel_attr = b_attr;
      sel_key  = b_key;
    end else begin
      sel_ppn  = p_ppn;
      sel_perm = p_perm;
      sel_attr = p_attr;
      sel_key  = p_key;
    end
  end

  cause_e chk_cause;
  xlat_perm_check u_chk_perm (
    .priv(req_priv), .kind(kind), .perm(sel_perm), .key(sel_key), .cause(chk_cause)
  );

  cause_e            cause_d;
  logic [PA_W-1:0]   pa_d;
  logic [2:0]        attr_d;
  logic              ref_d, chg_d;
  always_comb begin
    cause_d   = (b_hit || p_hit) ? chk_cause : CAUSE_MISS;
    upd_en    = req_vld && pg_sel && (chk_cause == CAUSE_NONE);
    upd_store = (kind == KIND_STORE);
    pa_d      = '0;
    attr_d    = '0;
    ref_d     = 1'b0;
    chg_d     = 1'b0;
    if (cause_d == CAUSE_NONE) begin
      pa_d   = {sel_ppn, lk_ofs};
      attr_d = sel_attr;
    end
    if (pg_sel) begin
      if (chk_cause == CAUSE_NONE) begin
        ref_d = 1'b1;
        chg_d = p_chg || upd_store;
      end else begin
        ref_d = p_ref;
        chg_d = p_chg;
      end
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      res_vld <= 1'b0;
    end else begin
      res_vld <= req_vld;
    end
  end

  cause_e cause_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      res_pa   <= '0;
      res_attr <= '0;
      cause_q  <= CAUSE_NONE;
      res_ref  <= 1'b0;
      res_chg  <= 1'b0;
      res_hit  <= 1'b0;
    end else if (req_vld) begin
      res_pa   <= pa_d;
      res_attr <= attr_d;
      cause_q  <= cause_d;
      res_ref  <= ref_d;
      res_chg  <= chg_d;
      res_hit  <= (cause_d == CAUSE_NONE);
    end
  end
  assign res_cause = cause_q;
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic        req_priv,
  input logic [1:0]  req_kind,
  input logic        res_vld,
  input logic [31:0] res_pa,
  input logic [2:0]  res_attr,
  input logic        res_hit,
  input logic [1:0]  res_cause,
  input logic        res_ref,
  input logic        res_chg
);
  p_lat_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld);

  p_lat_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !res_vld);

  p_hit_agrees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_hit == (res_cause == 2'd0)));

  p_miss_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_cause == 2'd1) |->
      (res_pa == '0 && res_attr == '0 && !res_ref && !res_chg));

  p_sup_load_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_priv && req_kind == 2'd0) |=> (res_cause != 2'd2));

  p_key_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_priv) |=> (res_cause != 2'd3));

  p_chg_has_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_chg) |-> res_ref);
endmodule

bind xlat_unit xlat_unit_chk u_xlat_chk (
  .clk(clk), .rst_n(rst_s),
  .req_vld(req_vld), .req_priv(req_priv), .req_kind(req_kind),
  .res_vld(res_vld), .res_pa(res_pa), .res_attr(res_attr), .res_hit(res_hit),
  .res_cause(res_cause), .res_ref(res_ref), .res_chg(res_chg)
);

// File: tb/sim_xlat_unit.sv
module sim_xlat_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n;
  logic        req_vld, req_priv;
  logic [51:0] req_va;
  logic [1:0]  req_kind;
  logic        wr_en, wr_page, wr_vld, wr_key;
  logic [2:0]  wr_idx, wr_attr;
  logic [39:0] wr_vpn;
  logic [19:0] wr_mask, wr_ppn;
  logic [3:0]  wr_perm;
  logic        res_vld, res_hit, res_ref, res_chg;
  logic [31:0] res_pa;
  logic [2:0]  res_attr;
  logic [1:0]  res_cause;

  xlat_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_va(req_va), .req_priv(req_priv), .req_kind(req_kind),
    .wr_en(wr_en), .wr_page(wr_page), .wr_idx(wr_idx), .wr_vld(wr_vld),
    .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_ppn(wr_ppn), .wr_perm(wr_perm),
    .wr_attr(wr_attr), .wr_key(wr_key),
    .res_vld(res_vld), .res_pa(res_pa), .res_attr(res_attr), .res_hit(res_hit),
    .res_cause(res_cause), .res_ref(res_ref), .res_chg(res_chg)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit armed = 0;
  bit done = 0;

  // behavioural model of both banks
  bit          mb_v [4];
  logic [39:0] mb_vpn [4];
  logic [19:0] mb_mask [4], mb_ppn [4];
  logic [3:0]  mb_perm [4];
  logic [2:0]  mb_attr [4];
  bit          mb_key [4];
  bit          mp_v [8], mp_r [8], mp_c [8], mp_key [8];
  logic [39:0] mp_vpn [8];
  logic [19:0] mp_ppn [8];
  logic [3:0]  mp_perm [8];
  logic [2:0]  mp_attr [8];

  string       cur_tag = "R1";
  string       e_tag = "R1";
  bit          e_vld = 0;
  logic [31:0] e_pa;
  logic [2:0]  e_attr;
  logic        e_hit, e_ref, e_chg;
  logic [1:0]  e_cause;

  initial begin
    for (int i = 0; i < 4; i++) mb_v[i] = 0;
    for (int i = 0; i < 8; i++) begin mp_v[i] = 0; mp_r[i] = 0; mp_c[i] = 0; end
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      e_vld = req_vld;
      if (req_vld) begin : lookup
        logic [39:0] vpn;
        int bi, pj;
        logic [3:0] pm;
        bit ky, ok;
        logic [19:0] frame;
        logic [2:0] at;
        vpn = req_va[51:12];
        bi = -1; pj = -1;
        for (int i = 0; i < 4; i++)
          if (bi < 0 && mb_v[i] &&
              ((vpn | {20'h0, mb_mask[i]}) == (mb_vpn[i] | {20'h0, mb_mask[i]}))) bi = i;
        for (int j = 0; j < 8; j++)
          if (pj < 0 && mp_v[j] && vpn == mp_vpn[j]) pj = j;
        e_tag = cur_tag;
        e_pa = 0; e_attr = 0; e_ref = 0; e_chg = 0;
        if (bi < 0 && pj < 0) begin
          e_cause = 2'd1;
        end else begin
          if (bi >= 0) begin
            pm = mb_perm[bi]; ky = mb_key[bi]; at = mb_attr[bi];
            frame = (mb_ppn[bi] & ~mb_mask[bi]) | (vpn[19:0] & mb_mask[bi]);
          end else begin
            pm = mp_perm[pj]; ky = mp_key[pj]; at = mp_attr[pj]; frame = mp_ppn[pj];
          end
          if (req_kind == 2'd1)      ok = req_priv ? pm[2] : pm[1];
          else if (req_kind == 2'd2) ok = pm[3] && (req_priv || pm[0]);
          else                       ok = req_priv || pm[0];
          if (ky && !req_priv) e_cause = 2'd3;
          else if (!ok)        e_cause = 2'd2;
          else                 e_cause = 2'd0;
          if (e_cause == 2'd0) begin
            e_pa = {frame, req_va[11:0]};
            e_attr = at;
          end
          if (bi < 0) begin
            if (e_cause == 2'd0) begin
              mp_r[pj] = 1;
              if (req_kind == 2'd1) mp_c[pj] = 1;
            end
            e_ref = mp_r[pj];
            e_chg = mp_c[pj];
          end
        end
        e_hit = (e_cause == 2'd0);
      end
      if (wr_en) begin
        if (!wr_page && wr_idx < 4) begin
          mb_v[wr_idx] = wr_vld; mb_vpn[wr_idx] = wr_vpn; mb_mask[wr_idx] = wr_mask;
          mb_ppn[wr_idx] = wr_ppn; mb_perm[wr_idx] = wr_perm; mb_attr[wr_idx] = wr_attr;
          mb_key[wr_idx] = wr_key;
        end else if (wr_page) begin
          mp_v[wr_idx] = wr_vld; mp_vpn[wr_idx] = wr_vpn; mp_ppn[wr_idx] = wr_ppn;
          mp_perm[wr_idx] = wr_perm; mp_attr[wr_idx] = wr_attr; mp_key[wr_idx] = wr_key;
          mp_r[wr_idx] = 0; mp_c[wr_idx] = 0;
        end
      end
    end else begin
      e_vld = 0;
    end
  end

  task automatic note(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare with the model away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      note(res_vld == e_vld, "R1", "res_vld", 64'(res_vld), 64'(e_vld));
      if (e_vld && res_vld)
        note({res_pa, res_attr, res_hit, res_cause, res_ref, res_chg} ==
             {e_pa, e_attr, e_hit, e_cause, e_ref, e_chg}, e_tag,
             "{pa,attr,hit,cause,ref,chg}",
             64'({res_pa, res_attr, res_hit, res_cause, res_ref, res_chg}),
             64'({e_pa, e_attr, e_hit, e_cause, e_ref, e_chg}));
    end
  end

  task automatic clear_inputs();
    req_vld = 0; req_va = '0; req_priv = 0; req_kind = 0;
    wr_en = 0; wr_page = 0; wr_idx = 0; wr_vld = 0; wr_vpn = '0;
    wr_mask = '0; wr_ppn = '0; wr_perm = 0; wr_attr = 0; wr_key = 0;
  endtask

  task automatic set_wr(bit pg, int idx, bit v, logic [39:0] vpn, logic [19:0] mask,
                        logic [19:0] ppn, logic [3:0] perm, logic [2:0] attr, bit key);
    wr_en = 1; wr_page = pg; wr_idx = 3'(idx); wr_vld = v; wr_vpn = vpn;
    wr_mask = mask; wr_ppn = ppn; wr_perm = perm; wr_attr = attr; wr_key = key;
  endtask

  task automatic set_req(logic [39:0] vpn, logic [11:0] ofs, bit priv, logic [1:0] kind,
                         string tag);
    req_vld = 1; req_va = {vpn, ofs}; req_priv = priv; req_kind = kind; cur_tag = tag;
  endtask

  task automatic write_entry(bit pg, int idx, bit v, logic [39:0] vpn, logic [19:0] mask,
                             logic [19:0] ppn, logic [3:0] perm, logic [2:0] attr, bit key);
    @(negedge clk);
    set_wr(pg, idx, v, vpn, mask, ppn, perm, attr, key);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic access(logic [39:0] vpn, logic [11:0] ofs, bit priv, logic [1:0] kind,
                        string tag);
    @(negedge clk);
    set_req(vpn, ofs, priv, kind, tag);
    @(negedge clk);
    clear_inputs();
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    note(res_vld == 0 && res_hit == 0, "R1", "reset state {vld,hit}",
         64'({res_vld, res_hit}), 64'(0));
    armed = 1;

    // R2 / R8: page mapping and status bits
    write_entry(1, 0, 1, 40'h00_0001_2345, 20'h0, 20'hABCDE, 4'b1111, 3'b101, 0);
    access(40'h00_0001_2345, 12'h678, 0, 2'd0, "R2");
    access(40'h00_0001_2345, 12'h010, 0, 2'd1, "R8");
    access(40'h00_0001_2345, 12'hFFF, 1, 2'd0, "R8");
    // R5: miss
    access(40'h00_0001_2346, 12'h000, 1, 2'd0, "R5");
    // R3: block with mask
    write_entry(0, 1, 1, 40'h00_0004_5600, 20'h000FF, 20'h55500, 4'b1111, 3'b010, 0);
    access(40'h00_0004_56AB, 12'h123, 0, 2'd0, "R3");
    access(40'h00_0004_57AB, 12'h123, 0, 2'd0, "R3");
    // R4: block beats page, lowest block index wins
    write_entry(1, 2, 1, 40'h00_0004_56AB, 20'h0, 20'h11111, 4'b1111, 3'b111, 0);
    access(40'h00_0004_56AB, 12'h456, 1, 2'd1, "R4");
    write_entry(0, 0, 1, 40'h00_0004_5000, 20'h00FFF, 20'h77000, 4'b1111, 3'b001, 0);
    access(40'h00_0004_56AB, 12'h456, 1, 2'd0, "R4");
    // R6: permissions
    write_entry(1, 3, 1, 40'h00_0000_0300, 20'h0, 20'h00300, 4'b0001, 3'b000, 0);
    write_entry(1, 4, 1, 40'h00_0000_0400, 20'h0, 20'h00400, 4'b1000, 3'b100, 0);
    access(40'h00_0000_0300, 12'h004, 0, 2'd0, "R6");
    access(40'h00_0000_0300, 12'h004, 0, 2'd1, "R6");
    access(40'h00_0000_0300, 12'h004, 1, 2'd1, "R6");
    access(40'h00_0000_0300, 12'h004, 1, 2'd2, "R6");
    access(40'h00_0000_0400, 12'h008, 1, 2'd2, "R6");
    access(40'h00_0000_0400, 12'h008, 0, 2'd2, "R6");
    access(40'h00_0000_0400, 12'h008, 1, 2'd0, "R6");
    // R7: key bit
    write_entry(1, 5, 1, 40'h00_0000_0500, 20'h0, 20'h00500, 4'b0000, 3'b011, 1);
    access(40'h00_0000_0500, 12'h00C, 0, 2'd0, "R7");
    access(40'h00_0000_0500, 12'h00C, 0, 2'd1, "R7");
    access(40'h00_0000_0500, 12'h00C, 1, 2'd0, "R7");
    // R10: kind 3 acts as a load
    access(40'h00_0000_0300, 12'h020, 0, 2'd3, "R10");
    access(40'h00_0000_0400, 12'h020, 0, 2'd3, "R10");
    // last page slot, all-ones address
    write_entry(1, 7, 1, 40'hFF_FFFF_FFFF, 20'h0, 20'hFFFFF, 4'b1111, 3'b110, 0);
    access(40'hFF_FFFF_FFFF, 12'hFFF, 0, 2'd2, "R2");
    // R9: write and store on the same page entry in one cycle
    @(negedge clk);
    set_wr(1, 0, 1, 40'h00_0001_2345, 20'h0, 20'h22222, 4'b1111, 3'b001, 0);
    set_req(40'h00_0001_2345, 12'h0AA, 0, 2'd1, "R9");
    @(negedge clk);
    clear_inputs();
    access(40'h00_0001_2345, 12'h0AA, 0, 2'd0, "R9");
    write_entry(1, 0, 0, 40'h00_0001_2345, 20'h0, 20'h22222, 4'b1111, 3'b001, 0);
    access(40'h00_0001_2345, 12'h0AA, 1, 2'd0, "R9");
    // R1: back-to-back requests
    @(negedge clk);
    set_req(40'h00_0000_0300, 12'h100, 0, 2'd0, "R1");
    @(negedge clk);
    set_req(40'hFF_FFFF_FFFF, 12'h001, 1, 2'd1, "R1");
    @(negedge clk);
    set_req(40'h00_0004_5ABC, 12'h002, 0, 2'd2, "R1");
    @(negedge clk);
    set_req(40'h12_3456_7890, 12'h003, 1, 2'd0, "R1");
    @(negedge clk);
    set_req(40'h00_0004_5612, 12'h004, 0, 2'd1, "R1");
    @(negedge clk);
    clear_inputs();
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule